// File: doc/BRIEF.md
# Big-endian byte-lane load/store unit

This unit sits between a processor core and a 32-bit word-wide synchronous data memory. For every request it forms a byte address from a base register value and a 17-bit signed offset. It then drives the memory with a word address, a per-byte write mask and lane-aligned write data. Word operations scale the offset by four. Byte operations use the offset as a byte count. Byte lanes are numbered big-endian: select value 0 is the most significant byte of the memory word.

A load returns in the cycle after it is issued. This matches a memory that registers its read data on the clock edge that accepts the request. A byte load picks out the addressed lane and sign-extends it. A word load passes the word through unchanged. A word access whose address is not a multiple of four is flagged and never reaches the memory.

The request side is a valid-only stream and has no back-pressure. The unit accepts one operation in every cycle in which `req_valid` is high. The load result is a valid-only stream with no ready, so the consumer must take `ld_data` in the cycle in which `ld_valid` is high. The memory side is plain control: there is one access in each cycle in which `mem_req` is high.

Top module: `lsu_be`

## Requirements
- R1: For a word operation (op 00 load word, 10 store word), the effective byte address is base + 4 × offset, and `mem_waddr` carries that address with its two low bits removed.
- R2: For a byte operation (op 01 load byte, 11 store byte), the effective byte address is base + offset with no scaling; its two low bits form the lane select and its upper bits drive `mem_waddr`.
- R3: The offset is treated as a two's-complement 17-bit value (bit 16 is the sign) and is extended before it is scaled or added, so negative offsets reach lower addresses.
- R4: A store word (op 10) asserts `mem_we`, sets all four `mem_be` bits and presents the store data unchanged on `mem_wdata`.
- R5: A store byte (op 11) asserts exactly one `mem_be` bit. Lane select 00 maps to bit 3, which covers data bits 31:24, and select 11 maps to bit 0, which covers bits 7:0. The low 8 bits of the store data are placed on that lane, the other lanes carry zero, and the upper 24 source bits have no effect.
- R6: A load byte (op 01) returns the selected lane, with select 00 taking memory bits 31:24 and select 11 taking bits 7:0, sign-extended to 32 bits.
- R7: A load word (op 00) returns the 32-bit memory word unchanged.
- R8: `ld_valid` is high for one cycle exactly one cycle after each accepted load request, and `ld_data` is valid in that cycle. Stores never raise `ld_valid`.
- R9: A word operation whose effective address has nonzero low two bits raises `misalign` in the request cycle and keeps `mem_req` and `mem_we` low. A misaligned store therefore leaves memory unchanged, and a misaligned load produces no `ld_valid`.
- R10: While reset is asserted and in the first cycle after it, `ld_valid`, `mem_req` and `mem_we` are low as long as no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation presented this cycle |
| req_op | input | 2 | 00 load word, 01 load byte, 10 store word, 11 store byte |
| req_base | input | 32 | Base register value |
| req_imm | input | 17 | Signed offset immediate |
| req_wdata | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_waddr | output | 30 | Word address |
| mem_be | output | 4 | Byte write mask, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Registered read word from memory |
| misalign | output | 1 | Word access to a non-multiple-of-four address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, a 32-bit byte address and a 17-bit offset. These are the sizes at which the sign bit of the offset, the scaling by four and all four big-endian lanes can each be reached with small addresses. Every request is run against a byte-array reference that knows nothing of lanes or masks. Word stores are read back lane by lane, byte stores are read back as words, and offsets are tried both negative and positive. A misaligned store is followed by a load that proves memory was left untouched.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_LDB = 2'b01,
    OP_STW = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;
endpackage

// File: rtl/lsu_be_agen.sv
module lsu_be_agen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 17,
  parameter int SEL_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic              is_word,
  output logic [ADDR_W-1:0] addr,
  output logic              unaligned
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_sx;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    imm_sx    = {{EXT_W{imm[IMM_W-1]}}, imm};
    offset    = is_word ? (imm_sx << SEL_W) : imm_sx;
    addr      = base + offset;
    unaligned = is_word && (addr[SEL_W-1:0] != '0);
  end
endmodule

// File: rtl/lsu_be_wlane.sv
module lsu_be_wlane #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int SEL_W  = $clog2(LANES)
) (
  input  logic [SEL_W-1:0]  lane_sel,
  input  logic              is_byte,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = (lane_sel == SEL_W'(LANES - 1 - i));
    assign be[i] = is_byte ? hit : 1'b1;
    assign lane_data[8*i +: 8] = is_byte ? (hit ? wdata[7:0] : 8'h00)
                                         : wdata[8*i +: 8];
  end
endmodule

// File: rtl/lsu_be_rlane.sv
module lsu_be_rlane #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int SEL_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [SEL_W-1:0]  lane_sel,
  input  logic              is_byte,
  output logic [DATA_W-1:0] result
);
  logic [7:0] lane_byte [LANES];
  logic [7:0] picked;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign lane_byte[i] = rdata[8*(LANES-1-i) +: 8];
  end

  always_comb begin
    picked = lane_byte[lane_sel];
    result = is_byte ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
  end
endmodule

// File: rtl/lsu_be.sv
module lsu_be #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 17,
  parameter int LANES  = DATA_W / 8,
  parameter int SEL_W  = $clog2(LANES),
  parameter int WADR_W = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WADR_W-1:0] mem_waddr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  import lsu_be_pkg::*;

  lsu_op_e           op;
  logic              is_word, is_store;
  logic [ADDR_W-1:0] eff_addr;
  logic              unaligned;
  logic              ld_valid_q;
  logic              byte_q;
  logic [SEL_W-1:0]  sel_q;

  assign op       = lsu_op_e'(req_op);
  assign is_word  = (op == OP_LDW) || (op == OP_STW);
  assign is_store = (op == OP_STW) || (op == OP_STB);

  lsu_be_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SEL_W(SEL_W)) u_agen (
    .base      (req_base),
    .imm       (req_imm),
    .is_word   (is_word),
    .addr      (eff_addr),
    .unaligned (unaligned)
  );

  assign misalign  = req_valid && unaligned;
  assign mem_req   = req_valid && !unaligned;
  assign mem_we    = mem_req && is_store;
  assign mem_waddr = eff_addr[ADDR_W-1:SEL_W];

  lsu_be_wlane #(.DATA_W(DATA_W), .LANES(LANES), .SEL_W(SEL_W)) u_wlane (
    .lane_sel  (eff_addr[SEL_W-1:0]),
    .is_byte   (!is_word),
    .wdata     (req_wdata),
    .be        (mem_be),
    .lane_data (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_q <= 1'b0;
      byte_q     <= 1'b0;
      sel_q      <= '0;
    end else begin
      ld_valid_q <= mem_req && !is_store;
      if (mem_req && !is_store) begin
        byte_q <= !is_word;
        sel_q  <= eff_addr[SEL_W-1:0];
      end
    end
  end

  assign ld_valid = ld_valid_q;

  lsu_be_rlane #(.DATA_W(DATA_W), .LANES(LANES), .SEL_W(SEL_W)) u_rlane (
    .rdata    (mem_rdata),
    .lane_sel (sel_q),
    .is_byte  (byte_q),
    .result   (ld_data)
  );
endmodule

// File: rtl/lsu_be_chk.sv
module lsu_be_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              mem_req,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic              misalign,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data
);
  assert_word_store_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_op == 2'b10) |-> (mem_be == {LANES{1'b1}}));

  assert_byte_store_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_op == 2'b11) |-> ($countones(mem_be) == 1));

  assert_byte_load_signext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_op == 2'b01) |=>
      (ld_valid && (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}})));

  assert_load_valid_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && !req_op[1]));

  assert_store_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !ld_valid);

  assert_misalign_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_req && !mem_we));

  assert_misalign_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign && !req_op[1]) |=> !ld_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_req && !mem_we));
endmodule

bind lsu_be lsu_be_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .misalign  (misalign),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data)
);

// File: tb/lsu_be_tb.sv
`timescale 1ns/1ps
module lsu_be_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_base = '0;
  logic [16:0] req_imm = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we, misalign, ld_valid;
  logic [29:0] mem_waddr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata, ld_data;

  int vectors = 0;
  int miss = 0;
  bit done = 0;

  logic [31:0] ram [0:63];
  logic [7:0]  mdl [0:255];

  always #4 clk = ~clk;

  lsu_be u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= ram[mem_waddr[5:0]];
      if (mem_we)
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) ram[mem_waddr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  endtask

  // op: 0 LW, 1 LB, 2 SW, 3 SB
  task automatic do_op(input logic [1:0] op, input logic [31:0] base,
                       input logic [16:0] imm, input logic [31:0] wd,
                       input string tag);
    int simm;
    logic [31:0] ea;
    bit word, store, bad;
    logic [3:0] ebe;
    logic [31:0] ewd, eld;
    simm  = imm[16] ? int'(imm) - 131072 : int'(imm);
    word  = (op == 2'd0) || (op == 2'd2);
    store = op[1];
    ea    = base + (word ? 32'(simm * 4) : 32'(simm));
    bad   = word && (ea[1:0] != 2'b00);
    ebe   = word ? 4'hF : (4'b1000 >> ea[1:0]);
    ewd   = word ? wd : (32'(wd[7:0]) << (8 * (3 - ea[1:0])));
    if (word) eld = {mdl[{ea[7:2],2'd0}], mdl[{ea[7:2],2'd1}], mdl[{ea[7:2],2'd2}], mdl[{ea[7:2],2'd3}]};
    else      eld = {{24{mdl[ea[7:0]][7]}}, mdl[ea[7:0]]};

    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_base = base; req_imm = imm; req_wdata = wd;
    @(negedge clk);
    chk({tag, " R9 misalign"}, 32'(misalign), 32'(bad));
    chk({tag, " R9 mem_req"}, 32'(mem_req), 32'(!bad));
    chk({tag, " R4/R5 mem_we"}, 32'(mem_we), 32'(store && !bad));
    if (!bad) begin
      chk({tag, word ? " R1 waddr" : " R2 waddr"}, 32'(mem_waddr), 32'(ea[31:2]));
      if (store) begin
        chk({tag, word ? " R4 be" : " R5 be"}, 32'(mem_be), 32'(ebe));
        chk({tag, word ? " R4 wdata" : " R5 wdata"}, mem_wdata, ewd);
      end
    end
    @(posedge clk); #1;
    req_valid = 0;
    if (store && !bad)
      for (int i = 0; i < 4; i++)
        if (word) mdl[{ea[7:2], 2'(i)}] = wd[8*(3-i) +: 8];
        else if (i == 0) mdl[ea[7:0]] = wd[7:0];
    @(negedge clk);
    chk({tag, " R8 ld_valid"}, 32'(ld_valid), 32'(!store && !bad));
    if (!store && !bad)
      chk({tag, word ? " R7 ld_data" : " R6 ld_data"}, ld_data, eld);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) ram[i] = '0;
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ld_valid in reset", 32'(ld_valid), 0);
    chk("R10 mem_req in reset", 32'(mem_req), 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 ld_valid after reset", 32'(ld_valid), 0);
    chk("R10 mem_we after reset", 32'(mem_we), 0);

    do_op(2'd2, 32'd0,  17'd0, 32'hDEADBEEF, "SW base0");
    for (int i = 0; i < 4; i++) do_op(2'd1, 32'd0, 17'(i), 32'h0, "LB lane");
    do_op(2'd0, 32'd0,  17'd0, 32'h0, "LW word0");
    do_op(2'd2, 32'd16, 17'd3, 32'h0155AA7F, "SW R1 scaled");
    do_op(2'd0, 32'd28, 17'd0, 32'h0, "LW R1 readback");
    for (int i = 0; i < 4; i++)
      do_op(2'd3, 32'd40, 17'(i), 32'hFFFF_FF00 | 32'(8'h81 + i*8'h11), "SB R5 lane");
    do_op(2'd0, 32'd40, 17'd0, 32'h0, "LW after SB");
    do_op(2'd3, 32'd100, 17'h1FFFD, 32'h1234_5677, "SB R3 negimm");
    do_op(2'd1, 32'd97,  17'd0, 32'h0, "LB R3 readback");
    do_op(2'd2, 32'd128, 17'h1FFFE, 32'hCAFE_F00D, "SW R3 negimm");
    do_op(2'd0, 32'd120, 17'd0, 32'h0, "LW R3 readback");
    do_op(2'd1, 32'd120, 17'd2, 32'h0, "LB R6 positive");
    do_op(2'd2, 32'd2,   17'd0, 32'h1111_1111, "SW R9 misaligned");
    do_op(2'd0, 32'd1,   17'd1, 32'h0, "LW R9 misaligned");
    do_op(2'd0, 32'd0,   17'd0, 32'h0, "LW R9 untouched");
    do_op(2'd3, 32'd6,   17'd0, 32'h0000_0042, "SB R2 unaligned ok");
    do_op(2'd0, 32'd4,   17'd0, 32'h0, "LW R2 readback");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule